// File: doc/BRIEF.md
# DRAM Bank Issue Arbiter

This block picks, in each memory cycle, at most one bank whose waiting request may go out to the DRAM devices. Every bank presents the head of its request queue as a valid flag and a read/write flag. The block checks each head against the timing state it keeps and grants one eligible bank, found by a round-robin scan. The grant is combinational from the current state and inputs. All timing state is loaded at the clock edge that ends the issuing cycle.

The timing state has four parts. Each bank has a busy counter. Three shared data-bus counters cover the plain bus occupancy, the read-to-write turnaround and the rank-switch turnaround. Each rank has a sliding history of its recent activates, which caps how many it may issue within a window. A free-running age counter marks queued heads as old when it wraps. For some time after the wrap, only old heads may issue, so a bank that keeps losing the scan is still served. The timing values are inputs, so they can change per device setting. A build-time option replaces the rotating start position with a pseudo-random one that is redrawn every cycle.

Top module: `dram_bank_issue_arbiter`

## Requirements
- R1: After bank b issues, bank b is refused for exactly `cfg_bank_busy` cycles. It may issue again in the cycle after that.
- R2: After any issue, no bank may issue for `cfg_bus_busy` cycles.
- R3: After a read issues, a write is refused for `cfg_bus_busy + cfg_rd_to_wr` cycles.
- R4: After a read issues, a read to a different rank is refused for `cfg_bus_busy + cfg_rank_switch` cycles. A read to the same rank is refused only for `cfg_bus_busy` cycles. The rank of bank b is b / BANKS_PER_RANK.
- R5: After a write issues, reads and writes to any rank are refused for `cfg_bus_busy` cycles only.
- R6: A rank whose issues within the last FAW_WIN cycles number ACT_LIMIT or more is refused. Banks of other ranks are unaffected.
- R7: The age counter counts cycles since reset and wraps after AGE_PERIOD cycles. At the wrap, every bank with a valid head that is not issuing is marked old. While the counter exceeds twice `cfg_bank_busy` and at least one bank is marked old, only old banks may issue. A bank's old mark clears when it issues.
- R8: The scan starts at a pointer and grants the first eligible bank in increasing index order, wrapping at NUM_BANKS. After an issue, the pointer moves to one past the granted bank.
- R9: Reset clears all counters, histories and old marks, and sets the pointer to bank 0. With no valid head, `issue_valid` is 0.
- R10: A grant names a bank whose head is valid. `issue_write` equals that head's `head_write` (1 = write, 0 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | NUM_BANKS | Bank b has a request at its queue head |
| head_write | input | NUM_BANKS | Head of bank b is a write (1) or a read (0) |
| cfg_bank_busy | input | CNT_W | Cycles a bank stays busy after an issue |
| cfg_bus_busy | input | CNT_W | Cycles the data bus stays busy after an issue |
| cfg_rd_to_wr | input | CNT_W | Extra cycles before a write may follow a read |
| cfg_rank_switch | input | CNT_W | Extra cycles before a read to another rank may follow a read |
| issue_valid | output | 1 | A bank is granted this cycle |
| issue_bank | output | IDX_W | Index of the granted bank |
| issue_write | output | 1 | Granted request is a write |

## Verification
A single bank held valid shows the bank busy window by itself, because with that pattern the bus blocks for less time. Pairs of requests are issued in the orders read-then-same-rank-read, read-then-write, read-then-other-rank-read and write-then-either. Each order predicts a different first grant cycle, so the three bus counters and their load values can be told apart. A stream of reads to one rank, with a single read to the other rank injected, separates the activate window from the bus rules. All banks valid at once shows the scan order. A head left waiting over the age wrap shows the age override by whether it beats a bank the pointer would favour. The next grant then shows that the old mark was cleared.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

   // Index width that never collapses to zero bits.
   function automatic int idx_width(input int count);
      return (count <= 1) ? 1 : $clog2(count);
   endfunction

   typedef enum logic {
      REQ_READ  = 1'b0,
      REQ_WRITE = 1'b1
   } req_kind_e;

endpackage

// File: rtl/bank_busy_timer.sv
module bank_busy_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] busy_time,
   input  logic             mark_old,
   output logic             idle,
   output logic             old
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         old    <= 1'b0;
      end else begin
         if (load)
            remain <= busy_time;
         else if (remain != '0)
            remain <= remain - 1'b1;

         if (load)
            old <= 1'b0;
         else if (mark_old)
            old <= 1'b1;
      end
   end

   assign idle = (remain == '0);

   // the picker must never grant a bank whose timer is running
   assert_busy_bank_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> !load);

endmodule

// File: rtl/rank_act_window.sv
module rank_act_window #(
   parameter int WIN   = 16,
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mark,
   output logic full
);

   localparam int CW = $clog2(WIN + 1);

   logic [WIN-1:0] hist;
   logic [CW-1:0]  marks;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist <= '0;
      else
         hist <= {hist[WIN-2:0], mark};
   end

   assign marks = CW'($countones(hist));
   assign full  = (marks >= CW'(LIMIT));

   assert_window_full_no_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !mark);

endmodule

// File: rtl/bank_rr_picker.sv
module bank_rr_picker #(
   parameter int N            = 8,
   parameter bit RANDOM_START = 1'b0,
   localparam int IW          = bank_arb_pkg::idx_width(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  eligible,
   output logic          grant_valid,
   output logic [IW-1:0] grant_idx,
   output logic [N-1:0]  grant_vec
);

   logic [IW-1:0] start;

   generate
      if (RANDOM_START) begin : g_rand
         logic [15:0] lfsr;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lfsr <= 16'hACE1;
            else
               lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         end
         assign start = lfsr[IW-1:0];
      end else begin : g_rr
         logic [IW-1:0] ptr;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptr <= '0;
            else if (grant_valid)
               ptr <= (grant_idx == IW'(N - 1)) ? '0 : grant_idx + 1'b1;
         end
         assign start = ptr;

         assert_pointer_bank_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
            eligible[ptr] |-> (grant_valid && grant_idx == ptr));
      end
   endgenerate

   always_comb begin
      int slot;
      grant_valid = 1'b0;
      grant_idx   = '0;
      for (int i = 0; i < N; i++) begin
         slot = int'(start) + i;
         if (slot >= N)
            slot = slot - N;
         if (!grant_valid && eligible[slot]) begin
            grant_valid = 1'b1;
            grant_idx   = IW'(slot);
         end
      end
      grant_vec = '0;
      if (grant_valid)
         grant_vec[grant_idx] = 1'b1;
   end

   assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

endmodule

// File: rtl/dram_bank_issue_arbiter.sv
module dram_bank_issue_arbiter #(
   parameter int NUM_BANKS      = 8,
   parameter int BANKS_PER_RANK = 4,
   parameter int CNT_W          = 6,
   parameter int FAW_WIN        = 16,
   parameter int ACT_LIMIT      = 4,
   parameter int AGE_PERIOD     = 64,
   parameter bit RANDOM_START   = 1'b0,
   localparam int IDX_W         = bank_arb_pkg::idx_width(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] head_valid,
   input  logic [NUM_BANKS-1:0] head_write,
   input  logic [CNT_W-1:0]     cfg_bank_busy,
   input  logic [CNT_W-1:0]     cfg_bus_busy,
   input  logic [CNT_W-1:0]     cfg_rd_to_wr,
   input  logic [CNT_W-1:0]     cfg_rank_switch,
   output logic                 issue_valid,
   output logic [IDX_W-1:0]     issue_bank,
   output logic                 issue_write
);

   import bank_arb_pkg::*;

   localparam int NUM_RANKS = NUM_BANKS / BANKS_PER_RANK;
   localparam int RANK_W    = idx_width(NUM_RANKS);
   localparam int TW        = CNT_W + 1;
   localparam int AGE_W     = idx_width(AGE_PERIOD);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || BANKS_PER_RANK < 1 || (NUM_BANKS % BANKS_PER_RANK) != 0)
      $error("bank count must be a multiple of banks per rank");
   if (FAW_WIN < 2 || FAW_WIN > 62 || ACT_LIMIT < 1 || ACT_LIMIT > FAW_WIN)
      $error("activate window settings out of range");
   if (AGE_PERIOD < 2 || CNT_W < 1)
      $error("age period or counter width out of range");
   if (RANDOM_START && ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || IDX_W > 16))
      $error("random start needs a power-of-two bank count");

   logic [NUM_BANKS-1:0] eligible, grant_vec, bank_idle, bank_old, mark_old;
   logic [NUM_RANKS-1:0] rank_full, rank_mark;
   logic [TW-1:0]        bus_any, bus_wr, bus_nr;
   logic [RANK_W-1:0]    last_rank, issue_rank;
   logic [IDX_W-1:0]     rank_wide;
   logic [AGE_W-1:0]     age;
   logic                 age_wrap, age_force;
   req_kind_e            issue_kind;

   assign rank_wide  = issue_bank / IDX_W'(BANKS_PER_RANK);
   assign issue_rank = rank_wide[RANK_W-1:0];
   assign issue_kind = req_kind_e'(head_write[issue_bank]);
   assign issue_write = issue_valid && (issue_kind == REQ_WRITE);

   // age tracking: wrap marks waiting heads as old
   assign age_wrap  = (age == AGE_W'(AGE_PERIOD - 1));
   assign age_force = (32'(age) > (32'(cfg_bank_busy) << 1)) && (|bank_old);

   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= '0;
      else
         age <= age_wrap ? '0 : age + 1'b1;
   end

   // per-bank timers and eligibility
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int RK = b / BANKS_PER_RANK;
      logic ok;

      assign mark_old[b] = age_wrap && head_valid[b];

      bank_busy_timer #(.CNT_W(CNT_W)) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (grant_vec[b]),
         .busy_time (cfg_bank_busy),
         .mark_old  (mark_old[b]),
         .idle      (bank_idle[b]),
         .old       (bank_old[b])
      );

      always_comb begin
         ok = head_valid[b] && bank_idle[b] && (bus_any == '0) && !rank_full[RK];
         if (head_write[b] && (bus_wr != '0))
            ok = 1'b0;
         if (!head_write[b] && (RANK_W'(RK) != last_rank) && (bus_nr != '0))
            ok = 1'b0;
         if (age_force && !bank_old[b])
            ok = 1'b0;
      end
      assign eligible[b] = ok;
   end

   // per-rank activate windows
   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign rank_mark[r] = issue_valid && (issue_rank == RANK_W'(r));

      rank_act_window #(.WIN(FAW_WIN), .LIMIT(ACT_LIMIT)) u_win (
         .clk   (clk),
         .rst_n (rst_n),
         .mark  (rank_mark[r]),
         .full  (rank_full[r])
      );
   end

   bank_rr_picker #(.N(NUM_BANKS), .RANDOM_START(RANDOM_START)) u_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .eligible    (eligible),
      .grant_valid (issue_valid),
      .grant_idx   (issue_bank),
      .grant_vec   (grant_vec)
   );

   // shared data-bus counters and last rank
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_any   <= '0;
         bus_wr    <= '0;
         bus_nr    <= '0;
         last_rank <= '0;
      end else if (issue_valid) begin
         last_rank <= issue_rank;
         bus_any   <= TW'(cfg_bus_busy);
         if (issue_write) begin
            bus_wr <= TW'(cfg_bus_busy);
            bus_nr <= TW'(cfg_bus_busy);
         end else begin
            bus_wr <= TW'(cfg_bus_busy) + TW'(cfg_rd_to_wr);
            bus_nr <= TW'(cfg_bus_busy) + TW'(cfg_rank_switch);
         end
      end else begin
         if (bus_any != '0) bus_any <= bus_any - 1'b1;
         if (bus_wr  != '0) bus_wr  <= bus_wr  - 1'b1;
         if (bus_nr  != '0) bus_nr  <= bus_nr  - 1'b1;
      end
   end

   assert_grant_has_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> head_valid[issue_bank]);

   assert_bus_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_any != '0) |-> !issue_valid);

   assert_write_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_write) |-> (bus_wr == '0));

   assert_rank_switch_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_write && issue_rank != last_rank) |-> (bus_nr == '0));

   assert_age_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age_force && issue_valid) |-> bank_old[issue_bank]);

endmodule

// File: tb/dram_bank_issue_arbiter_tb_top.sv
module dram_bank_issue_arbiter_tb_top;

   localparam int NB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] head_valid = '0;
   logic [NB-1:0] head_write = '0;
   logic [5:0]    cfg_bank_busy = '0, cfg_bus_busy = '0, cfg_rd_to_wr = '0, cfg_rank_switch = '0;
   logic          issue_valid, issue_write;
   logic [2:0]    issue_bank;

   int n_tests = 0;
   int n_fail  = 0;
   int wd      = 0;

   always #4 clk = ~clk;   // 125 MHz

   dram_bank_issue_arbiter dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .head_valid      (head_valid),
      .head_write      (head_write),
      .cfg_bank_busy   (cfg_bank_busy),
      .cfg_bus_busy    (cfg_bus_busy),
      .cfg_rd_to_wr    (cfg_rd_to_wr),
      .cfg_rank_switch (cfg_rank_switch),
      .issue_valid     (issue_valid),
      .issue_bank      (issue_bank),
      .issue_write     (issue_write)
   );

   always @(posedge clk) begin
      wd++;
      if (wd > 50000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      head_valid = '0;
      head_write = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;   // the current cycle is cycle 0
   endtask

   task automatic set_cfg(int bank_b, int bus_b, int rw, int rk);
      cfg_bank_busy   = 6'(bank_b);
      cfg_bus_busy    = 6'(bus_b);
      cfg_rd_to_wr    = 6'(rw);
      cfg_rank_switch = 6'(rk);
   endtask

   // check the grant of the current cycle, then move to the next cycle
   task automatic expect_grant(string tag, int exp);
      int act;
      #1;
      act = issue_valid ? int'(issue_bank) : -1;
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: grant actual %0d expected %0d", tag, act, exp);
      end
      @(negedge clk);
   endtask

   task automatic expect_bit(string tag, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      set_cfg(2, 0, 0, 0);
      do_reset();
      expect_grant("R9 no valid head", -1);
      head_valid = '1;
      head_write = 8'h01;
      #1;
      expect_bit("R10 write flag of bank 0", issue_write, 1'b1);
      expect_grant("R9 pointer at bank 0", 0);
      head_write = '0;
      #1;
      expect_bit("R10 read flag of bank 1", issue_write, 1'b0);
      expect_grant("R8 next after 0", 1);
   endtask

   task automatic t_bank_busy();
      set_cfg(3, 1, 0, 0);
      do_reset();
      head_valid = 8'h04;
      expect_grant("R1 first issue", 2);
      for (int c = 1; c <= 3; c++) expect_grant("R1 bank busy", -1);
      expect_grant("R1 bank free again", 2);
   endtask

   task automatic t_bus_same_rank();
      set_cfg(1, 3, 2, 4);
      do_reset();
      head_valid = 8'h03;
      expect_grant("R2 first read", 0);
      for (int c = 1; c <= 3; c++) expect_grant("R2 bus busy", -1);
      expect_grant("R4 same-rank read after bus", 1);
   endtask

   task automatic t_read_to_write();
      set_cfg(1, 3, 2, 4);
      do_reset();
      head_valid = 8'h01;
      expect_grant("R3 read", 0);
      head_valid = 8'h02;
      head_write = 8'h02;
      for (int c = 1; c <= 5; c++) expect_grant("R3 write held", -1);
      expect_grant("R3 write released", 1);
   endtask

   task automatic t_rank_switch();
      set_cfg(1, 3, 2, 4);
      do_reset();
      head_valid = 8'h01;
      expect_grant("R4 read rank 0", 0);
      head_valid = 8'h10;
      for (int c = 1; c <= 7; c++) expect_grant("R4 other rank held", -1);
      expect_grant("R4 other rank released", 4);
   endtask

   task automatic t_write_first();
      set_cfg(1, 3, 2, 4);
      do_reset();
      head_valid = 8'h01;
      head_write = 8'h01;
      expect_grant("R5 write", 0);
      head_valid = 8'h10;
      head_write = 8'h00;
      for (int c = 1; c <= 3; c++) expect_grant("R5 read held", -1);
      expect_grant("R5 other-rank read after plain gap", 4);

      do_reset();
      head_valid = 8'h01;
      head_write = 8'h01;
      expect_grant("R5 write", 0);
      head_valid = 8'h02;
      head_write = 8'h02;
      for (int c = 1; c <= 3; c++) expect_grant("R5 write held", -1);
      expect_grant("R5 write after plain gap", 1);
   endtask

   task automatic t_act_window();
      set_cfg(1, 1, 0, 0);
      do_reset();
      head_valid = 8'h0F;
      for (int c = 0; c < 8; c++)
         expect_grant("R6 fill window", (c % 2 == 0) ? c / 2 : -1);
      head_valid = 8'h1F;
      expect_grant("R6 other rank passes", 4);
      head_valid = 8'h0F;
      for (int c = 9; c <= 16; c++) expect_grant("R6 rank window full", -1);
      expect_grant("R6 oldest mark expired", 0);
   endtask

   task automatic t_round_robin();
      set_cfg(2, 0, 0, 0);
      do_reset();
      head_valid = '1;
      for (int c = 0; c < 8; c++) expect_grant("R8 scan order", c);
   endtask

   task automatic t_age();
      set_cfg(3, 0, 0, 0);
      do_reset();
      for (int c = 0; c < 62; c++) @(negedge clk);
      head_valid = 8'h20;
      head_write = 8'h20;
      expect_grant("R7 bank 5 issues", 5);
      expect_grant("R7 bank 5 busy over wrap", -1);
      head_valid = '0;
      for (int c = 64; c < 71; c++) @(negedge clk);
      head_valid = 8'h21;
      expect_grant("R7 old bank beats pointer", 5);
      head_valid = 8'h01;
      expect_grant("R7 old mark cleared", 0);
   endtask

   initial begin
      t_reset();
      t_bank_busy();
      t_bus_same_rank();
      t_read_to_write();
      t_rank_switch();
      t_write_first();
      t_act_window();
      t_round_robin();
      t_age();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule